// File: doc/BRIEF.md
# Periodic Alarm Comparator with Repeat Masks

This block holds a programmable alarm time (seconds, minutes, hours and day of month, all BCD) and compares it against the running time bus of a separate clock block. The comparison is made once per one-second tick. When the enabled fields agree, the block raises a one-cycle interrupt pulse. The top bit of each alarm byte marks that field as "don't care". The pattern of these four mask bits, not a separate mode field, sets how often the alarm repeats: monthly, daily, hourly, once a minute or every second.

Software programs the block through a plain register port. Writes are validated per field, and a byte whose BCD value is out of range is dropped. Accepted bytes are kept whole, mask bit included, and read back unmodified. A control byte holds an enable bit that gates the interrupt. The register port, the time bus, the tick and the interrupt are all plain control and status pins. None of them carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `periodic_alarm`

## Requirements
- R1: After reset, every readable address returns 0x00 and `irq_pulse` is low.
- R2: Address 0 (alarm seconds) and address 1 (alarm minutes) accept a write only when bits 6:4 are a tens digit of at most 5 and bits 3:0 are a units digit of at most 9. An accepted write stores the full byte, including bit 7. A rejected write leaves the stored byte unchanged.
- R3: Address 2 (alarm hours) accepts a write only when bits 5:0 form a valid BCD value from 00 to 23. The full byte is stored; a rejected write changes nothing.
- R4: Address 3 (alarm date) accepts a write only when bits 5:0 form a valid BCD value from 01 to 31, so a date field of zero is rejected. The full byte is stored; a rejected write changes nothing.
- R5: Address 4 is the control byte. Every write is stored and read back, and bit 0 is the alarm enable. Addresses 5 to 7 read 0x00, and writes to them have no effect.
- R6: With bit 7 clear in all four alarm bytes, a tick raises a pulse only when seconds (bits 6:0), minutes (bits 6:0), hours (bits 5:0) and date (bits 5:0) all equal the time bus.
- R7: With only the date mask set (address 3, bit 7), the date is ignored and seconds, minutes and hours must match (daily repeat).
- R8: With the date and hour masks set and the others clear, only minutes and seconds must match (hourly repeat).
- R9: With the date, hour and minute masks set and the seconds mask clear, only seconds must match (repeat each minute).
- R10: Any other mask pattern makes every tick produce a pulse.
- R11: Matching is evaluated only in a cycle where `tick_1s` is high. The pulse appears in the following cycle and lasts exactly one cycle. A matching time with no tick produces no pulse.
- R12: When the enable bit is clear, no pulse is produced, whatever the time and the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| tick_1s | input | 1 | One-cycle pulse once per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| irq_pulse | output | 1 | One-cycle alarm interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit register bytes, a 3-bit address with the control byte at 4, and the enable on bit 0. With these values the whole address space can be reached, including the three dead addresses. Every mask pattern that the decoder distinguishes can be programmed, together with one pattern that is not on the repeat ladder. Boundary BCD values at each field limit (59, 60, 23, 24, 00, 31, 32, and digit values above 9) are exercised, along with a masked byte that has an empty date field.

// File: rtl/periodic_alarm_pkg.sv
package periodic_alarm_pkg;

  localparam int NFIELD   = 4;
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DATE = 3;
  localparam int MASK_BIT = 7;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MIN,
    RPT_SEC
  } repeat_e;

  // Bits of each field that carry the BCD value.
  function automatic logic [7:0] field_bits(input int idx);
    case (idx)
      FLD_SEC, FLD_MIN: return 8'h7F;
      default:          return 8'h3F;
    endcase
  endfunction

  function automatic int field_lo(input int idx);
    return (idx == FLD_DATE) ? 1 : 0;
  endfunction

  function automatic int field_hi(input int idx);
    case (idx)
      FLD_SEC, FLD_MIN: return 59;
      FLD_HOUR:         return 23;
      default:          return 31;
    endcase
  endfunction

  // Checks digit validity and the numeric range of one field.
  function automatic logic field_ok(input int idx, input logic [7:0] raw);
    logic [7:0] f;
    int         val;
    f   = raw & field_bits(idx);
    val = int'(f[7:4]) * 10 + int'(f[3:0]);
    return (f[3:0] <= 4'd9) && (val >= field_lo(idx)) && (val <= field_hi(idx));
  endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import periodic_alarm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [NFIELD-1:0][DATA_W-1:0]  alarm_q,
  output logic [DATA_W-1:0]              ctrl_q
);

  localparam int NADDR = 1 << ADDR_W;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    logic accept;
    assign accept = wr_en && (addr == ADDR_W'(g)) && field_ok(g, 8'(wdata));
    always_ff @(posedge clk) begin
      if (!rst_n)      alarm_q[g] <= '0;
      else if (accept) alarm_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                     ctrl_q <= '0;
    else if (wr_en && addr == ADDR_W'(CTRL_ADDR))   ctrl_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NADDR; i++) begin
      if (addr == ADDR_W'(i)) begin
        if (i < NFIELD)          rdata = alarm_q[i];
        else if (i == CTRL_ADDR) rdata = ctrl_q;
      end
    end
  end

endmodule

// File: rtl/alarm_mask_decode.sv
module alarm_mask_decode
  import periodic_alarm_pkg::*;
(
  input  logic [NFIELD-1:0] mask_bits,
  output logic [NFIELD-1:0] cmp_en
);

  repeat_e rate;

  always_comb begin
    case (mask_bits)
      4'b0000: rate = RPT_MONTH;
      4'b1000: rate = RPT_DAY;
      4'b1100: rate = RPT_HOUR;
      4'b1110: rate = RPT_MIN;
      default: rate = RPT_SEC;
    endcase
  end

  always_comb begin
    case (rate)
      RPT_MONTH: cmp_en = 4'b1111;
      RPT_DAY:   cmp_en = 4'b0111;
      RPT_HOUR:  cmp_en = 4'b0011;
      RPT_MIN:   cmp_en = 4'b0001;
      default:   cmp_en = 4'b0000;
    endcase
  end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import periodic_alarm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          enable,
  input  logic [NFIELD-1:0][DATA_W-1:0] alarm_q,
  input  logic [NFIELD-1:0][DATA_W-1:0] now,
  input  logic [NFIELD-1:0]             cmp_en,
  output logic                          irq
);

  logic [NFIELD-1:0] fld_hit;

  for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
    logic [DATA_W-1:0] sel;
    assign sel        = DATA_W'(field_bits(g));
    assign fld_hit[g] = !cmp_en[g] || (((alarm_q[g] ^ now[g]) & sel) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick && enable && (&fld_hit);
  end

endmodule

// File: rtl/periodic_alarm.sv
module periodic_alarm
  import periodic_alarm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 4,
  parameter int EN_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_1s,
  input  logic [DATA_W-1:0] now_sec,
  input  logic [DATA_W-1:0] now_min,
  input  logic [DATA_W-1:0] now_hour,
  input  logic [DATA_W-1:0] now_date,
  output logic              irq_pulse
);

  logic [NFIELD-1:0][DATA_W-1:0] alarm_q;
  logic [NFIELD-1:0][DATA_W-1:0] now_bus;
  logic [DATA_W-1:0]             ctrl_q;
  logic [NFIELD-1:0]             mask_bits;
  logic [NFIELD-1:0]             cmp_en;

  assign now_bus[FLD_SEC]  = now_sec;
  assign now_bus[FLD_MIN]  = now_min;
  assign now_bus[FLD_HOUR] = now_hour;
  assign now_bus[FLD_DATE] = now_date;

  for (genvar g = 0; g < NFIELD; g++) begin : g_mask
    assign mask_bits[g] = alarm_q[g][MASK_BIT];
  end

  alarm_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .alarm_q(alarm_q), .ctrl_q(ctrl_q)
  );

  alarm_mask_decode u_dec (
    .mask_bits(mask_bits), .cmp_en(cmp_en)
  );

  alarm_match #(.DATA_W(DATA_W)) u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick_1s), .enable(ctrl_q[EN_BIT]),
    .alarm_q(alarm_q), .now(now_bus), .cmp_en(cmp_en), .irq(irq_pulse)
  );

endmodule

// File: rtl/periodic_alarm_chk.sv
module periodic_alarm_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 4,
  parameter int EN_BIT    = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              tick_1s,
  input logic              irq_pulse,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] sec_q
);

  a_r11_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(tick_1s));

  a_r12_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(ctrl_q[EN_BIT]));

  a_r2_bad_sec_held: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && (reg_wdata[3:0] > 4'd9 || reg_wdata[6:4] > 3'd5))
    |=> $stable(sec_q));

  a_r2_good_sec_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && reg_wdata[3:0] <= 4'd9 && reg_wdata[6:4] <= 3'd5)
    |=> sec_q == $past(reg_wdata));

  a_r5_ctrl_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(CTRL_ADDR)) |=> ctrl_q == $past(reg_wdata));

endmodule

bind periodic_alarm periodic_alarm_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .EN_BIT(EN_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tick_1s(tick_1s), .irq_pulse(irq_pulse),
  .ctrl_q(ctrl_q), .sec_q(alarm_q[0])
);

// File: tb/periodic_alarm_tb.sv
module periodic_alarm_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_1s = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = '0;
  logic       irq_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bit    exp_q[$];
  string tag_q[$];
  logic  tick_d = 1'b0;

  always #4 clk = ~clk;

  periodic_alarm u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_1s(tick_1s),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .irq_pulse(irq_pulse)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Monitor: compares the cycle after each tick against the scoreboard.
  always @(posedge clk) tick_d <= tick_1s;
  always @(negedge clk) begin
    if (tick_d) begin
      bit    e;
      string t;
      if (exp_q.size() == 0) begin
        e = 1'b0; t = "R11 unexpected";
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
      end
      check(t, {7'd0, irq_pulse}, {7'd0, e});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic do_tick(input string req, input logic [7:0] s, input logic [7:0] m,
                         input logic [7:0] h, input logic [7:0] d, input bit exp);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_date = d;
    tick_1s = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    tick_1s = 1'b0;
    @(negedge clk);
    check("R11 pulse width", {7'd0, irq_pulse}, 8'h00);
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd_check("R1 reset read", 3'(a), 8'h00);
    check("R1 reset irq", {7'd0, irq_pulse}, 8'h00);

    // R2 seconds/minutes validation
    wr(0, 8'h59); rd_check("R2 sec 59", 0, 8'h59);
    wr(0, 8'h60); rd_check("R2 sec 60 rejected", 0, 8'h59);
    wr(0, 8'h0A); rd_check("R2 sec 0A rejected", 0, 8'h59);
    wr(0, 8'hB0); rd_check("R2 sec masked 30", 0, 8'hB0);
    wr(1, 8'h45); rd_check("R2 min 45", 1, 8'h45);
    wr(1, 8'h5A); rd_check("R2 min 5A rejected", 1, 8'h45);
    // R3 hours
    wr(2, 8'h23); rd_check("R3 hour 23", 2, 8'h23);
    wr(2, 8'h24); rd_check("R3 hour 24 rejected", 2, 8'h23);
    wr(2, 8'h1A); rd_check("R3 hour 1A rejected", 2, 8'h23);
    wr(2, 8'h92); rd_check("R3 hour masked 12", 2, 8'h92);
    // R4 date
    wr(3, 8'h00); rd_check("R4 date 00 rejected", 3, 8'h00);
    wr(3, 8'h31); rd_check("R4 date 31", 3, 8'h31);
    wr(3, 8'h32); rd_check("R4 date 32 rejected", 3, 8'h31);
    wr(3, 8'h80); rd_check("R4 masked zero date rejected", 3, 8'h31);
    // R5 control and dead addresses
    wr(4, 8'h00); rd_check("R5 ctrl", 4, 8'h00);
    wr(5, 8'hFF); rd_check("R5 addr5 ignored", 5, 8'h00);
    wr(7, 8'h55); rd_check("R5 addr7 ignored", 7, 8'h00);

    // Monthly alarm 12th 08:15:30
    wr(0, 8'h30); wr(1, 8'h15); wr(2, 8'h08); wr(3, 8'h12);
    do_tick("R12 disabled no pulse", 8'h30, 8'h15, 8'h08, 8'h12, 1'b0);
    wr(4, 8'h01); rd_check("R5 ctrl enable", 4, 8'h01);
    // R11 matching time without tick
    @(negedge clk);
    now_sec = 8'h30; now_min = 8'h15; now_hour = 8'h08; now_date = 8'h12;
    repeat (3) @(negedge clk);
    check("R11 no tick no pulse", {7'd0, irq_pulse}, 8'h00);
    do_tick("R6 monthly match", 8'h30, 8'h15, 8'h08, 8'h12, 1'b1);
    do_tick("R6 sec differs", 8'h31, 8'h15, 8'h08, 8'h12, 1'b0);
    do_tick("R6 date differs", 8'h30, 8'h15, 8'h08, 8'h13, 1'b0);
    // R7 daily
    wr(3, 8'h92);
    do_tick("R7 daily other date", 8'h30, 8'h15, 8'h08, 8'h05, 1'b1);
    do_tick("R7 hour differs", 8'h30, 8'h15, 8'h09, 8'h05, 1'b0);
    // R8 hourly
    wr(2, 8'h88);
    do_tick("R8 hourly other hour", 8'h30, 8'h15, 8'h17, 8'h01, 1'b1);
    do_tick("R8 min differs", 8'h30, 8'h16, 8'h17, 8'h01, 1'b0);
    // R9 each minute
    wr(1, 8'h95);
    do_tick("R9 minute other min", 8'h30, 8'h44, 8'h17, 8'h01, 1'b1);
    do_tick("R9 sec differs", 8'h31, 8'h44, 8'h17, 8'h01, 1'b0);
    // R10 every second: all masks, then only the seconds mask
    wr(0, 8'hB0);
    do_tick("R10 all masks", 8'h01, 8'h02, 8'h03, 8'h04, 1'b1);
    wr(1, 8'h15); wr(2, 8'h08); wr(3, 8'h12);
    do_tick("R10 sec mask only", 8'h59, 8'h00, 8'h00, 8'h01, 1'b1);
    // R12 disable again
    wr(4, 8'h00);
    do_tick("R12 disabled every-second", 8'h59, 8'h00, 8'h00, 8'h01, 1'b0);

    repeat (2) @(negedge clk);
    check("R11 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule